// File: doc/BRIEF.md
# Temperature-Aware Refresh Interval Scheduler

This block paces periodic refresh for a DRAM device with two ranks. A free-running prescaler counts controller clock cycles. The length of one refresh interval comes from three parameters: the clock period, the retention window, and the number of refresh commands that window needs. Each time the prescaler passes a rank's tick point, that rank owes one more refresh. A rank raises its request while it owes anything. The controller sends an acknowledge each time it issues a refresh to that rank.

The block reads a case-temperature input and a separate hot flag. If the device is hot, the retention window halves and so the interval halves. The new rate is taken only at an interval boundary, so a count in progress is never cut short. The second rank's tick sits half an interval after the first rank's, so the two ranks do not ask at the same time. A refresh is only legal on a rank whose banks are all closed, so each request carries an indication that the rank must be all-idle before it is served.

Top module: `refresh_scheduler`

## Requirements
- R1: At the normal rate the interval is NORM_LEN = floor(floor(WINDOW_NS/REF_COUNT)*1000/CLK_PERIOD_PS) cycles. Rank 0's owed count rises once per interval, first after cycle NORM_LEN following reset release.
- R2: When the latched rate is fast, the interval is FAST_LEN = floor(NORM_LEN/2) cycles. The fast rate is selected when tempC > HOT_LIMIT_C, or when hotFlag is high, at the moment of sampling.
- R3: The rate is sampled only on the cycle that ends rank 0's interval, and the `fastRate` output shows the latched rate. After reset the rate is normal.
- R4: Each rank's owed count rises by one on its tick and saturates at OWE_DEPTH. It never rises by more than one per cycle.
- R5: An acknowledge lowers that rank's owed count by one. An acknowledge while the count is zero is ignored. A tick and an acknowledge in the same cycle leave the count unchanged.
- R6: `refReq[r]` and `needAllIdle[r]` are high exactly when rank r's owed count is nonzero.
- R7: `overTemp` is high one cycle after tempC ≥ MAX_LIMIT_C is sampled. Such a temperature also selects the fast rate.
- R8: Rank 1 ticks when the prescaler phase equals floor(len/2)−1, and rank 0 ticks at phase len−1, where len is the current interval. The two ranks' counts never rise in the same cycle.
- R9: While rst_n is low, all owed counts, requests, `fastRate` and `overTemp` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tempC | input | TEMP_W | Case temperature in °C, unsigned |
| hotFlag | input | 1 | Forces the fast rate when high |
| refAck | input | 2 | Per-rank refresh issued, one cycle pulse |
| refReq | output | 2 | Per-rank refresh owed |
| needAllIdle | output | 2 | Per-rank: banks must be idle before serving |
| owedCnt | output | 2*OWE_W | Owed counts, rank 0 in low bits |
| fastRate | output | 1 | Latched rate, 1 = doubled refresh rate |
| overTemp | output | 1 | Temperature at or above the upper limit |

## Verification
The bench builds the block with a 40 ns interval at a 4 ns clock. That gives a normal interval of 10 cycles and a fast interval of 5, so each saturation, drain and rate switch happens within a few dozen cycles. With intervals this short, the bench can sweep every temperature from 0 to 130 °C. Each temperature is held for a span that does not divide the interval, so rate changes fall at every prescaler phase. Random acknowledge patterns run alongside the sweep. A cycle-by-cycle arithmetic model gives the expected counts, requests, rate and over-temperature flag.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  localparam int RANK_N = 2;

  // strobes from control to the per-rank owed counters
  typedef struct packed {
    logic [RANK_N-1:0] rankTick;
  } ctrl_strobes_t;
endpackage

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int NORM_LEN    = 10,
  parameter int TEMP_W      = 8,
  parameter int HOT_LIMIT_C = 85,
  parameter int MAX_LIMIT_C = 95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] tempC,
  input  logic              hotFlag,
  output ctrl_strobes_t     strb,
  output logic              fastRate,
  output logic              overTemp
);
  localparam int FAST_LEN = NORM_LEN / 2;
  localparam int CNT_W    = $clog2(NORM_LEN);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] curLen;
  logic [CNT_W-1:0] endCnt;
  logic [CNT_W-1:0] midCnt;
  logic             wantFast;
  logic             atEnd;

  always_comb begin
    curLen   = fastRate ? CNT_W'(FAST_LEN) : CNT_W'(NORM_LEN);
    endCnt   = curLen - CNT_W'(1);
    midCnt   = (curLen >> 1) - CNT_W'(1);
    atEnd    = (phaseCnt == endCnt);
    wantFast = hotFlag | (tempC > TEMP_W'(HOT_LIMIT_C));
    strb.rankTick[0] = atEnd;
    strb.rankTick[1] = (phaseCnt == midCnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
      fastRate <= 1'b0;
      overTemp <= 1'b0;
    end else begin
      overTemp <= (tempC >= TEMP_W'(MAX_LIMIT_C));
      if (atEnd) begin
        phaseCnt <= '0;
        fastRate <= wantFast;
      end else begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int OWE_DEPTH = 8,
  parameter int OWE_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_strobes_t           strb,
  input  logic [RANK_N-1:0]       refAck,
  output logic [RANK_N*OWE_W-1:0] owedCnt
);
  for (genvar r = 0; r < RANK_N; r++) begin : g_rank
    logic [OWE_W-1:0] owed;
    logic             ackEff;
    logic             atMax;

    assign ackEff = refAck[r] && (owed != '0);
    assign atMax  = (owed == OWE_W'(OWE_DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        owed <= '0;
      end else if (strb.rankTick[r] && !ackEff) begin
        if (!atMax) owed <= owed + OWE_W'(1);
      end else if (!strb.rankTick[r] && ackEff) begin
        owed <= owed - OWE_W'(1);
      end
    end

    assign owedCnt[r*OWE_W +: OWE_W] = owed;
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 1250,
  parameter int WINDOW_NS     = 64000000,
  parameter int REF_COUNT     = 8192,
  parameter int OWE_DEPTH     = 8,
  parameter int TEMP_W        = 8,
  parameter int HOT_LIMIT_C   = 85,
  parameter int MAX_LIMIT_C   = 95,
  localparam int INTERVAL_NS  = WINDOW_NS / REF_COUNT,
  localparam int NORM_LEN     = INTERVAL_NS * 1000 / CLK_PERIOD_PS,
  localparam int OWE_W        = $clog2(OWE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] tempC,
  input  logic              hotFlag,
  input  logic [1:0]        refAck,
  output logic [1:0]        refReq,
  output logic [1:0]        needAllIdle,
  output logic [2*OWE_W-1:0] owedCnt,
  output logic              fastRate,
  output logic              overTemp
);
  ctrl_strobes_t strb;

  refsched_ctrl #(
    .NORM_LEN(NORM_LEN), .TEMP_W(TEMP_W),
    .HOT_LIMIT_C(HOT_LIMIT_C), .MAX_LIMIT_C(MAX_LIMIT_C)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tempC(tempC), .hotFlag(hotFlag),
    .strb(strb), .fastRate(fastRate), .overTemp(overTemp)
  );

  refsched_dp #(.OWE_DEPTH(OWE_DEPTH), .OWE_W(OWE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .refAck(refAck), .owedCnt(owedCnt)
  );

  for (genvar r = 0; r < 2; r++) begin : g_req
    assign refReq[r]      = (owedCnt[r*OWE_W +: OWE_W] != '0);
    assign needAllIdle[r] = refReq[r];
  end
endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
  parameter int OWE_DEPTH   = 8,
  parameter int OWE_W       = 4,
  parameter int TEMP_W      = 8,
  parameter int MAX_LIMIT_C = 95
) (
  input logic               clk,
  input logic               rst_n,
  input logic [TEMP_W-1:0]  tempC,
  input logic [1:0]         refAck,
  input logic [2*OWE_W-1:0] owedCnt,
  input logic               overTemp
);
  logic [OWE_W-1:0] owed0, owed1;
  assign owed0 = owedCnt[OWE_W-1:0];
  assign owed1 = owedCnt[2*OWE_W-1:OWE_W];

  a_r4_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (owed0 <= OWE_W'(OWE_DEPTH)) && (owed1 <= OWE_W'(OWE_DEPTH)));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (owed0 <= $past(owed0) + OWE_W'(1)) && (owed1 <= $past(owed1) + OWE_W'(1)));

  a_r5_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (owed0 == '0 && refAck[0]) |=> (owed0 <= OWE_W'(1)));

  a_r7_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (tempC >= TEMP_W'(MAX_LIMIT_C)) |=> overTemp);

  a_r8_no_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !((owed0 > $past(owed0)) && (owed1 > $past(owed1))));
endmodule

bind refresh_scheduler refsched_checker #(
  .OWE_DEPTH(OWE_DEPTH), .OWE_W(OWE_W), .TEMP_W(TEMP_W), .MAX_LIMIT_C(MAX_LIMIT_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tempC(tempC), .refAck(refAck),
  .owedCnt(owedCnt), .overTemp(overTemp)
);

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;
  localparam int PERIOD_PS = 4000;
  localparam int WIN_NS    = 327680;
  localparam int DEPTH     = 8;
  localparam int OWW       = 4;
  localparam int NLEN      = (WIN_NS / 8192) * 1000 / PERIOD_PS;  // 10
  localparam int FLEN      = NLEN / 2;                            // 5

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tempC = 8'd25;
  logic hotFlag = 1'b0;
  logic [1:0] refAck = 2'b00;
  logic [1:0] refReq, needAllIdle;
  logic [2*OWW-1:0] owedCnt;
  logic fastRate, overTemp;

  int checks = 0;
  int fails = 0;
  int mCnt = 0;
  bit mFast = 0;
  bit mOver = 0;
  int mOwed[2] = '{0, 0};
  int cycNo = 0;

  always #2 clk = ~clk;

  refresh_scheduler #(.CLK_PERIOD_PS(PERIOD_PS), .WINDOW_NS(WIN_NS), .OWE_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tempC(tempC), .hotFlag(hotFlag), .refAck(refAck),
    .refReq(refReq), .needAllIdle(needAllIdle), .owedCnt(owedCnt),
    .fastRate(fastRate), .overTemp(overTemp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cycNo, act, exp);
    end
  endtask

  function automatic int owedOf(input int r);
    return int'(owedCnt[r*OWW +: OWW]);
  endfunction

  task automatic modelStep();
    int len = mFast ? FLEN : NLEN;
    bit t[2];
    t[0] = (mCnt == len - 1);
    t[1] = (mCnt == len / 2 - 1);
    for (int r = 0; r < 2; r++) begin
      bit a = refAck[r] && mOwed[r] != 0;
      if (t[r] && !a) begin
        if (mOwed[r] < DEPTH) mOwed[r]++;
      end else if (!t[r] && a) mOwed[r]--;
    end
    mOver = (tempC >= 95);
    if (t[0]) begin
      mCnt = 0;
      mFast = hotFlag || (tempC > 85);
    end else mCnt++;
  endtask

  task automatic compareAll();
    for (int r = 0; r < 2; r++) begin
      check(owedOf(r) == mOwed[r], "R4/R5 owed count", owedOf(r), mOwed[r]);
      check(refReq[r] == (mOwed[r] != 0), "R6 request", refReq[r], mOwed[r] != 0);
      check(needAllIdle[r] == (mOwed[r] != 0), "R6 all-idle flag", needAllIdle[r], mOwed[r] != 0);
    end
    check(fastRate == mFast, "R2/R3 latched rate", fastRate, mFast);
    check(overTemp == mOver, "R7 over-temperature", overTemp, mOver);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    cycNo++;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(owedCnt == '0, "R9 reset owed", int'(owedCnt), 0);
    check(refReq == 2'b00 && needAllIdle == 2'b00, "R9 reset requests", int'(refReq), 0);
    check(!fastRate && !overTemp, "R9 reset flags", int'({fastRate, overTemp}), 0);
    tempC = 8'd120;  // hot during reset: rate still starts normal (R3)
    rst_n = 1'b1;

    // no acks: saturation, phase offset, normal interval
    for (int i = 0; i < 100; i++) begin
      cyc();
      if (cycNo == 4) check(owedOf(1) == 0, "R8 rank1 before mid", owedOf(1), 0);
      if (cycNo == 5) check(owedOf(1) == 1 && owedOf(0) == 0, "R8 rank1 first at mid", owedOf(1) * 10 + owedOf(0), 10);
      if (cycNo == 9) check(owedOf(0) == 0 && !fastRate, "R3 normal first interval", owedOf(0), 0);
      if (cycNo == 10) check(owedOf(0) == 1, "R1 rank0 first tick", owedOf(0), 1);
      if (cycNo == 10) tempC = 8'd25;
      if (cycNo == 10) check(fastRate == 1'b1, "R3 rate latched at boundary", fastRate, 1);
      if (cycNo == 15) check(owedOf(0) == 2, "R2 fast interval", owedOf(0), 2);
      if (cycNo == 99) check(owedOf(0) == DEPTH && owedOf(1) == DEPTH, "R4 saturation", owedOf(0), DEPTH);
    end

    // drain with acks; acks at zero ignored
    refAck = 2'b11;
    for (int i = 0; i < 30; i++) cyc();
    refAck = 2'b00;
    check(owedOf(0) <= 1 && owedOf(1) <= 1, "R5 drained", owedOf(0), 0);

    // hot flag with a cool temperature
    hotFlag = 1'b1;
    for (int i = 0; i < 40; i++) begin
      refAck = 2'($urandom_range(0, 3));
      cyc();
    end
    hotFlag = 1'b0;

    // temperature sweep; hold of 7 cycles moves changes across all phases
    for (int tv = 0; tv <= 130; tv++) begin
      tempC = 8'(tv);
      for (int k = 0; k < 7; k++) begin
        refAck = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
        cyc();
      end
      if (tv == 95) check(overTemp == 1'b1, "R7 limit reached", overTemp, 1);
      if (tv == 94) check(overTemp == 1'b0, "R7 below limit", overTemp, 0);
    end

    // cool down, sparse acks
    tempC = 8'd40;
    for (int i = 0; i < 60; i++) begin
      refAck = (i % 3 == 0) ? 2'b11 : 2'b00;
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule